// File: doc/BRIEF.md
# SDRAM Command Controller

This block sits between a simple host request port and one 16-bit SDRAM device with four banks. Each host request names a bank, a row and a column, and either writes one 16-bit word under a two-bit byte-enable or reads one word back. The controller turns every request into an ACTIVE command followed by a READ or WRITE with auto-precharge, so no row stays open between requests. It also runs the power-up sequence, programs the mode register, and schedules periodic auto-refresh.

Every gap between commands comes from a nanosecond parameter that is rounded up to whole clock cycles. A single countdown timer holds back the next command until that gap has elapsed. The mode register is loaded with burst length one, sequential ordering and the programmed CAS latency. Read data is captured from the device data bus that many cycles after the READ command and is returned with a one-cycle valid strobe. A refresh that falls due is issued before any new host request.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is high, the clock-enable output is low, the command pins show NOP, and `host_ack` and `host_rvalid` are low. The clock-enable output is high once reset is released. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE SET 0000.
- R2: After reset is released, only NOP appears for at least ceil(T_INIT_NS/CLK_NS) cycles. The first four other commands are then, in this order: PRECHARGE with A10 high (all banks), REFRESH, REFRESH, MODE SET. No ACTIVE, READ or WRITE appears before the MODE SET.
- R3: The MODE SET command drives bank 0 and the address word {A11..A7 = 0, A6..A4 = CAS latency, A3 = 0 (sequential), A2..A0 = 000 (burst of one)}. With CAS latency 3 this word is 0x030.
- R4: A READ or WRITE follows its ACTIVE by at least ceil(tRCD/CLK_NS) cycles.
- R5: The host address is laid out as bank = bits [21:20], row = bits [19:8], column = bits [7:0]. ACTIVE drives the row on A11..A0 and the bank on BA. READ and WRITE drive the column on A7..A0, drive A10 high (auto-precharge), and use the same bank.
- R6: The spacing between ACTIVE or REFRESH commands meets the following minimums: ACTIVE/REFRESH to ACTIVE/REFRESH is at least ceil(tRC). ACTIVE to the next ACTIVE is at least ceil(tRAS)+ceil(tRP). WRITE to the next ACTIVE or REFRESH is at least ceil(tWR)+ceil(tRP). READ to the next ACTIVE or REFRESH is at least 1+ceil(tRP). PRECHARGE to REFRESH is at least ceil(tRP). MODE SET to ACTIVE is at least ceil(tRSC).
- R7: In the WRITE cycle the write data is on `sd_dq_out` with `sd_dq_oe` high. `sd_dqm[1]` is the inverse of `host_be[1]` (upper byte) and `sd_dqm[0]` is the inverse of `host_be[0]` (lower byte). A byte whose enable is 0 is left unchanged in memory.
- R8: `host_rvalid` pulses for one cycle, exactly CAS_LAT+1 cycles after a READ on the pins. `host_rdata` then holds the value `sd_dq_in` had CAS_LAT cycles after that READ.
- R9: After initialisation, consecutive REFRESH commands are at most floor(REF_WINDOW_NS/REF_ROWS/CLK_NS) cycles apart (1953 at defaults). When a refresh is pending at an idle point, REFRESH is issued instead of accepting a host request.
- R10: `host_ack` is a single-cycle pulse, given only while `host_req` is high, exactly once per accepted request. The ACTIVE for that request appears on the pins in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | {bank, row, column} |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 1 = upper byte |
| host_ack | output | 1 | Request accepted |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid strobe |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks, high = masked |
| sd_dq_out | output | 16 | Data to device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Data from device |

## Verification
The checker tests the following every cycle: the ACTIVE-to-column and row-cycle spacing, the auto-precharge bit, the mode word, the byte-mask relation to the accepted enables, the exact read-valid latency, the refresh interval bound, refresh priority at idle points, and the acknowledge pulse shape. Some behaviours can only be shown by the bench scenarios, which use a device model that stores data. These are the exact power-up wait and command order, the requirement that a masked byte really keeps its old value, that every read returns the word last written to that address across banks and edge addresses, and that refresh keeps its rate while host traffic is present.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_PRE, S_REF1, S_REF2, S_MRS, S_IDLE, S_COL
  } ctl_state_e;

  // nanoseconds to whole cycles, rounding up
  function automatic int ns2cyc(int t_ns, int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // burst of one, sequential, latency in bits 6:4
  function automatic int mode_word(int cas_lat);
    return (cas_lat & 7) << 4;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         ready
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int TRIP = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_issued,
  output logic ref_pend
);
  localparam int W = $clog2(TRIP + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold || ref_issued) cnt <= W'(TRIP - 1);
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign ref_pend = (cnt == '0) && !hold;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int CL = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_on_pins,
  input  logic [DW-1:0] dq_in,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic [CL-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      stage  <= {stage[CL-2:0], rd_on_pins};
      rvalid <= stage[CL-1];
      if (stage[CL-1]) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CLK_NS        = 8,
  parameter int CAS_LAT       = 3,
  parameter int T_RCD_NS      = 18,
  parameter int T_RP_NS       = 18,
  parameter int T_RC_NS       = 60,
  parameter int T_RAS_NS      = 42,
  parameter int T_WR_NS       = 12,
  parameter int T_RRD_NS      = 12,
  parameter int T_RSC_NS      = 12,
  parameter int T_INIT_NS     = 200000,
  parameter int REF_WINDOW_NS = 64000000,
  parameter int REF_ROWS      = 4096,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 8,
  parameter int DW            = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              host_req,
  input  logic                              host_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0]     host_addr,
  input  logic [DW-1:0]                     host_wdata,
  input  logic [DW/8-1:0]                   host_be,
  output logic                              host_ack,
  output logic [DW-1:0]                     host_rdata,
  output logic                              host_rvalid,
  output logic                              sd_cke,
  output logic                              sd_cs_n,
  output logic                              sd_ras_n,
  output logic                              sd_cas_n,
  output logic                              sd_we_n,
  output logic [BANK_W-1:0]                 sd_ba,
  output logic [ROW_W-1:0]                  sd_a,
  output logic [DW/8-1:0]                   sd_dqm,
  output logic [DW-1:0]                     sd_dq_out,
  output logic                              sd_dq_oe,
  input  logic [DW-1:0]                     sd_dq_in
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int NLANE  = DW / 8;
  localparam int AP_BIT = 10;

  localparam int C_RCD  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int C_RP   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int C_RC   = ns2cyc(T_RC_NS, CLK_NS);
  localparam int C_RAS  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int C_WR   = ns2cyc(T_WR_NS, CLK_NS);
  localparam int C_RRD  = ns2cyc(T_RRD_NS, CLK_NS);
  localparam int C_RSC  = ns2cyc(T_RSC_NS, CLK_NS);
  localparam int C_INIT = ns2cyc(T_INIT_NS, CLK_NS);
  localparam int C_REFI = (REF_WINDOW_NS / REF_ROWS) / CLK_NS;

  // column command to next row command, per direction
  localparam int C_GAP_BASE = imax(imax(C_RC - C_RCD, C_RAS - C_RCD + C_RP), C_RRD - C_RCD);
  localparam int C_GAP_RD   = imax(C_GAP_BASE, 1 + C_RP);
  localparam int C_GAP_WR   = imax(C_GAP_BASE, C_WR + C_RP);
  localparam int C_GAP_MAX  = imax(C_GAP_RD, C_GAP_WR);
  // worst lateness of a refresh grant, including the tail of init
  localparam int MARGIN     = C_RCD + C_GAP_MAX + C_RC + C_RSC + 2;
  localparam int REF_TRIP   = C_REFI - MARGIN;
  localparam int TMR_W      = $clog2(imax(C_INIT, C_REFI) + 1);
  localparam logic [ROW_W-1:0] MODE_A = ROW_W'(mode_word(CAS_LAT));

  ctl_state_e st, st_n;
  sd_cmd_e    cmd_q, cmd_n;

  logic [BANK_W-1:0] ba_n;
  logic [ROW_W-1:0]  a_n;
  logic [NLANE-1:0]  dqm_n;
  logic [DW-1:0]     dq_n;
  logic              oe_n, ack_n;
  logic              tmr_load, tmr_ready;
  logic [TMR_W-1:0]  tmr_val;
  logic              latch_req;

  logic              q_we;
  logic [BANK_W-1:0] q_bank;
  logic [COL_W-1:0]  q_col;
  logic [DW-1:0]     q_wdata;
  logic [NLANE-1:0]  q_be;

  // named internal events, used by the checker
  logic issue_act, issue_col, issue_ref, init_done, ref_pend, idle_gate, rd_on_pins;

  sdram_gap_timer #(.W(TMR_W), .RST_VAL(C_INIT - 1)) gap_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .ready(tmr_ready)
  );

  sdram_refresh_sched #(.TRIP(REF_TRIP)) refsch_i (
    .clk(clk), .rst(rst), .hold(!init_done), .ref_issued(issue_ref), .ref_pend(ref_pend)
  );

  sdram_rd_capture #(.CL(CAS_LAT), .DW(DW)) rdcap_i (
    .clk(clk), .rst(rst), .rd_on_pins(rd_on_pins), .dq_in(sd_dq_in),
    .rvalid(host_rvalid), .rdata(host_rdata)
  );

  assign init_done  = (st == S_IDLE) || (st == S_COL);
  assign idle_gate  = (st == S_IDLE) && tmr_ready;
  assign issue_act  = (cmd_n == CMD_ACT);
  assign issue_ref  = (cmd_n == CMD_REF);
  assign issue_col  = (cmd_n == CMD_RD) || (cmd_n == CMD_WR);
  assign rd_on_pins = (cmd_q == CMD_RD);

  always_comb begin
    st_n      = st;
    cmd_n     = CMD_NOP;
    ba_n      = '0;
    a_n       = '0;
    dqm_n     = '0;
    dq_n      = '0;
    oe_n      = 1'b0;
    ack_n     = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    latch_req = 1'b0;
    if (tmr_ready) begin
      case (st)
        S_PRE: begin
          cmd_n = CMD_PRE; a_n[AP_BIT] = 1'b1;
          tmr_load = 1'b1; tmr_val = TMR_W'(C_RP - 1); st_n = S_REF1;
        end
        S_REF1: begin
          cmd_n = CMD_REF; tmr_load = 1'b1; tmr_val = TMR_W'(C_RC - 1); st_n = S_REF2;
        end
        S_REF2: begin
          cmd_n = CMD_REF; tmr_load = 1'b1; tmr_val = TMR_W'(C_RC - 1); st_n = S_MRS;
        end
        S_MRS: begin
          cmd_n = CMD_MRS; a_n = MODE_A;
          tmr_load = 1'b1; tmr_val = TMR_W'(C_RSC - 1); st_n = S_IDLE;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd_n = CMD_REF; tmr_load = 1'b1; tmr_val = TMR_W'(C_RC - 1);
          end else if (host_req) begin
            cmd_n     = CMD_ACT;
            ba_n      = host_addr[ADDR_W-1 -: BANK_W];
            a_n       = host_addr[COL_W +: ROW_W];
            ack_n     = 1'b1;
            latch_req = 1'b1;
            tmr_load  = 1'b1; tmr_val = TMR_W'(C_RCD - 1);
            st_n      = S_COL;
          end
        end
        S_COL: begin
          cmd_n = q_we ? CMD_WR : CMD_RD;
          ba_n  = q_bank;
          a_n[COL_W-1:0] = q_col;
          a_n[AP_BIT]    = 1'b1;
          if (q_we) begin
            dq_n = q_wdata; oe_n = 1'b1; dqm_n = ~q_be;
          end
          tmr_load = 1'b1;
          tmr_val  = q_we ? TMR_W'(C_GAP_WR - 1) : TMR_W'(C_GAP_RD - 1);
          st_n     = S_IDLE;
        end
        default: st_n = S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_PRE;
      cmd_q     <= CMD_NOP;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_a      <= '0;
      sd_dqm    <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      host_ack  <= 1'b0;
      q_we      <= 1'b0;
      q_bank    <= '0;
      q_col     <= '0;
      q_wdata   <= '0;
      q_be      <= '0;
    end else begin
      st        <= st_n;
      cmd_q     <= cmd_n;
      sd_cke    <= 1'b1;
      sd_ba     <= ba_n;
      sd_a      <= a_n;
      sd_dqm    <= dqm_n;
      sd_dq_out <= dq_n;
      sd_dq_oe  <= oe_n;
      host_ack  <= ack_n;
      if (latch_req) begin
        q_we    <= host_we;
        q_bank  <= host_addr[ADDR_W-1 -: BANK_W];
        q_col   <= host_addr[COL_W-1:0];
        q_wdata <= host_wdata;
        q_be    <= host_be;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int CAS_LAT = 3,
  parameter int C_RCD   = 3,
  parameter int C_RC    = 8,
  parameter int C_REFI  = 1953,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int NLANE   = 2,
  parameter int DW      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic [3:0]        cmd_pins,
  input logic [BANK_W-1:0] sd_ba,
  input logic [ROW_W-1:0]  sd_a,
  input logic [NLANE-1:0]  sd_dqm,
  input logic [DW-1:0]     sd_dq_in,
  input logic              host_req,
  input logic [NLANE-1:0]  host_be,
  input logic              host_ack,
  input logic              host_rvalid,
  input logic [DW-1:0]     host_rdata,
  input logic              init_done,
  input logic              ref_pend,
  input logic              idle_gate,
  input logic              issue_ref,
  input logic              issue_act
);
  logic act_p, ref_p, rd_p, wr_p, mrs_p, col_p;
  assign act_p = (cmd_pins == 4'b0011);
  assign ref_p = (cmd_pins == 4'b0001);
  assign rd_p  = (cmd_pins == 4'b0101);
  assign wr_p  = (cmd_pins == 4'b0100);
  assign mrs_p = (cmd_pins == 4'b0000);
  assign col_p = rd_p || wr_p;

  logic [15:0]      since_act, since_row, since_refp;
  logic [3:0]       since_rst;
  logic [NLANE-1:0] cap_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act  <= 16'hFFFF;
      since_row  <= 16'hFFFF;
      since_refp <= '0;
      since_rst  <= '0;
      cap_be     <= '0;
    end else begin
      since_act  <= act_p ? 16'd1 : ((since_act == 16'hFFFF) ? since_act : since_act + 1'b1);
      since_row  <= (act_p || ref_p) ? 16'd1 :
                    ((since_row == 16'hFFFF) ? since_row : since_row + 1'b1);
      since_refp <= ref_p ? 16'd1 :
                    ((since_refp == 16'hFFFF) ? since_refp : since_refp + 1'b1);
      since_rst  <= (since_rst == 4'hF) ? since_rst : since_rst + 1'b1;
      if (issue_act) cap_be <= host_be;
    end
  end

  // R1: reset state on the pins
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cmd_pins == 4'b0111 && !sd_cke && !host_ack && !host_rvalid));

  // R2: no row or column access before initialisation ends
  p_no_early_access_r2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !(act_p || col_p));

  // R3: mode word
  p_mode_word_r3: assert property (@(posedge clk) disable iff (rst)
    mrs_p |-> (sd_ba == '0 && sd_a == {{(ROW_W-7){1'b0}}, 3'(CAS_LAT), 4'b0000}));

  // R4: ACTIVE to column spacing
  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    col_p |-> (since_act >= 16'(C_RCD)));

  // R5: auto-precharge on every column command
  p_auto_pre_r5: assert property (@(posedge clk) disable iff (rst)
    col_p |-> sd_a[10]);

  // R6: row cycle between ACTIVE/REFRESH commands
  p_row_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (act_p || ref_p) |-> (since_row >= 16'(C_RC)));

  // R7: byte masks are the inverse of the accepted enables
  p_write_mask_r7: assert property (@(posedge clk) disable iff (rst)
    wr_p |-> (sd_dqm == ~cap_be));

  // R8: read valid latency and captured data
  p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst > 4'(CAS_LAT + 1)) |-> (host_rvalid == $past(rd_p, CAS_LAT + 1)));
  p_read_data_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && since_rst > 4'd1) |-> (host_rdata == $past(sd_dq_in)));

  // R9: refresh interval bound and priority
  p_refresh_bound_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (since_refp <= 16'(C_REFI)));
  p_refresh_first_r9: assert property (@(posedge clk) disable iff (rst)
    (ref_pend && idle_gate) |-> (issue_ref && !issue_act));

  // R10: acknowledge shape
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
  p_ack_with_act_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (act_p && $past(host_req)));

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
  .CAS_LAT(CAS_LAT), .C_RCD(C_RCD), .C_RC(C_RC), .C_REFI(C_REFI),
  .BANK_W(BANK_W), .ROW_W(ROW_W), .NLANE(NLANE), .DW(DW)
) chk_i (
  .clk(clk), .rst(rst), .sd_cke(sd_cke),
  .cmd_pins({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in),
  .host_req(host_req), .host_be(host_be), .host_ack(host_ack),
  .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .init_done(init_done), .ref_pend(ref_pend), .idle_gate(idle_gate),
  .issue_ref(issue_ref), .issue_act(issue_act)
);

// File: tb/sdram_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_tb_top;
  // timing restated from the requirements at an 8 ns clock
  localparam int P      = 8;
  localparam int B_CL   = 3;
  localparam int B_RCD  = (18 + P - 1) / P;
  localparam int B_RP   = (18 + P - 1) / P;
  localparam int B_RC   = (60 + P - 1) / P;
  localparam int B_RAS  = (42 + P - 1) / P;
  localparam int B_WR   = (12 + P - 1) / P;
  localparam int B_RSC  = (12 + P - 1) / P;
  localparam int B_INIT = (200000 + P - 1) / P;
  localparam int B_REFI = 64000000 / 4096 / P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        host_req = 1'b0, host_we = 1'b0;
  logic [21:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_ack, host_rvalid;
  logic [15:0] host_rdata;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = 16'h0;

  sdram_cmd_ctrl dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model and protocol monitor
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int cyc = 0, init_idx = 0, n_ref_run = 0, n_ack = 0, n_req = 0, rd_cnt = 0;
  int t_act = -100000, t_ref = -100000, t_rd = -100000, t_wr = -100000;
  int t_pre = -100000, t_mrs = -100000;
  bit mrs_done = 1'b0, prev_ack = 1'b0;
  logic [1:0]  open_bank = '0;
  logic [11:0] open_row = '0;
  logic [15:0] rd_data = '0;

  always @(negedge clk) begin
    logic [3:0] cmd;
    int k;
    logic [15:0] old;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst) begin
      check(cmd == 4'b0111 && !sd_cke && !host_ack && !host_rvalid, "R1", "reset pins",
            {cmd, sd_cke, host_ack, host_rvalid}, {4'b0111, 3'b000});
    end else begin
      if (cyc == 1) check(sd_cke == 1'b1, "R1", "cke after reset", sd_cke, 1);
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) sd_dq_in = rd_data;
      end
      if (host_rvalid) begin
        check(cyc - t_rd == B_CL + 1, "R8", "read valid latency", cyc - t_rd, B_CL + 1);
        if (exp_q.size() == 0) check(1'b0, "R8", "unexpected read data", host_rdata, 0);
        else begin
          old = exp_q.pop_front();
          check(host_rdata == old, "R8", "read data", host_rdata, old);
        end
      end
      if (host_ack) begin
        n_ack++;
        check(host_req && !prev_ack && cmd == 4'b0011, "R10", "ack pulse with ACTIVE",
              {host_req, prev_ack, cmd}, {2'b10, 4'b0011});
      end
      prev_ack = host_ack;
      case (cmd)
        4'b0010: begin
          check(init_idx == 0 && sd_a[10] && cyc >= B_INIT, "R2", "PRECHARGE ALL first",
                cyc, B_INIT);
          init_idx++; t_pre = cyc;
        end
        4'b0001: begin
          if (!mrs_done) begin
            check(init_idx == 1 || init_idx == 2, "R2", "REFRESH order", init_idx, 1);
            init_idx++;
          end else begin
            check(cyc - t_ref <= B_REFI, "R9", "refresh spacing", cyc - t_ref, B_REFI);
            n_ref_run++;
          end
          check(cyc - t_pre >= B_RP, "R6", "PRE to REF", cyc - t_pre, B_RP);
          check(cyc - t_ref >= B_RC && cyc - t_act >= B_RC, "R6", "row cycle before REF",
                (cyc - t_ref < cyc - t_act) ? cyc - t_ref : cyc - t_act, B_RC);
          check(cyc - t_wr >= B_WR + B_RP && cyc - t_rd >= 1 + B_RP, "R6",
                "column to REF", cyc - t_wr, B_WR + B_RP);
          t_ref = cyc;
        end
        4'b0000: begin
          check(init_idx == 3, "R2", "MODE SET order", init_idx, 3);
          check(sd_a == 12'(B_CL << 4) && sd_ba == 2'b00, "R3", "mode word", sd_a, B_CL << 4);
          init_idx++; mrs_done = 1'b1; t_mrs = cyc;
        end
        4'b0011: begin
          check(mrs_done, "R2", "ACTIVE after init", 0, 1);
          check(cyc - t_mrs >= B_RSC, "R6", "MODE SET to ACTIVE", cyc - t_mrs, B_RSC);
          check(cyc - t_act >= B_RC && cyc - t_act >= B_RAS + B_RP, "R6",
                "ACTIVE to ACTIVE", cyc - t_act, B_RAS + B_RP);
          check(cyc - t_ref >= B_RC, "R6", "REF to ACTIVE", cyc - t_ref, B_RC);
          check(cyc - t_wr >= B_WR + B_RP, "R6", "WRITE to ACTIVE", cyc - t_wr, B_WR + B_RP);
          check(cyc - t_rd >= 1 + B_RP, "R6", "READ to ACTIVE", cyc - t_rd, 1 + B_RP);
          open_bank = sd_ba; open_row = sd_a; t_act = cyc;
        end
        4'b0101, 4'b0100: begin
          check(mrs_done, "R2", "column after init", 0, 1);
          check(cyc - t_act >= B_RCD, "R4", "ACTIVE to column", cyc - t_act, B_RCD);
          check(sd_a[10] && sd_ba == open_bank, "R5", "auto-precharge and bank",
                {sd_a[10], sd_ba}, {1'b1, open_bank});
          k = int'({open_bank, open_row, sd_a[7:0]});
          old = mem.exists(k) ? mem[k] : 16'h0;
          if (cmd == 4'b0100) begin
            check(sd_dq_oe == 1'b1, "R7", "data drive on WRITE", sd_dq_oe, 1);
            mem[k] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                      sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
            t_wr = cyc;
          end else begin
            rd_cnt = B_CL; rd_data = old; t_rd = cyc;
          end
        end
        default: ;
      endcase
      cyc++;
    end
  end

  // scoreboard driver: one request, expected read value pushed on accept
  task automatic host_op(input bit we, input logic [21:0] addr, input logic [15:0] wd,
                         input logic [1:0] be);
    int k;
    logic [15:0] old;
    @(negedge clk); #1;
    host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; host_be = be;
    n_req++;
    k = int'(addr);
    old = shadow.exists(k) ? shadow[k] : 16'h0;
    if (we) shadow[k] = {be[1] ? wd[15:8] : old[15:8], be[0] ? wd[7:0] : old[7:0]};
    else exp_q.push_back(old);
    do @(negedge clk); while (!host_ack);
    #1 host_req = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    while (!mrs_done) @(negedge clk);
    // R7/R8: full words at the address extremes
    host_op(1, 22'h000000, 16'hA5C3, 2'b11);
    host_op(0, 22'h000000, 16'h0,    2'b11);
    host_op(1, 22'h3FFFFF, 16'h1234, 2'b11);
    host_op(0, 22'h3FFFFF, 16'h0,    2'b11);
    // R7: lower-only, upper-only and no-lane writes
    host_op(1, 22'h100010, 16'hFFFF, 2'b11);
    host_op(1, 22'h100010, 16'h00AB, 2'b01);
    host_op(0, 22'h100010, 16'h0,    2'b11);
    host_op(1, 22'h2ABC55, 16'h1111, 2'b11);
    host_op(1, 22'h2ABC55, 16'h5A00, 2'b10);
    host_op(0, 22'h2ABC55, 16'h0,    2'b11);
    host_op(1, 22'h2ABC55, 16'hEEEE, 2'b00);
    host_op(0, 22'h2ABC55, 16'h0,    2'b11);
    // R5: spread over banks, rows and columns
    for (int i = 0; i < 24; i++)
      host_op(1, {i[1:0], 12'(i * 37), 8'(i * 13)}, 16'(i * 16'h0F1D + 7), 2'b11);
    for (int i = 0; i < 24; i++)
      host_op(0, {i[1:0], 12'(i * 37), 8'(i * 13)}, 16'h0, 2'b11);
    // R9: refreshes while idle, then traffic around a refresh
    repeat (4200) @(negedge clk);
    for (int i = 0; i < 200; i++)
      host_op(i[0], {2'(i), 12'h5A5, 8'(i)}, 16'(i * 3 + 1), 2'b11);
    repeat (20) @(negedge clk);
    check(n_ref_run >= 2, "R9", "refreshes after init", n_ref_run, 2);
    check(cyc - t_ref <= B_REFI, "R9", "time since last refresh", cyc - t_ref, B_REFI);
    check(n_ack == n_req, "R10", "one ack per request", n_ack, n_req);
    check(exp_q.size() == 0, "R8", "all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10", "watchdog expired", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule